// File: doc/BRIEF.md
# Sixteen-Bit Timer with Auto-Reload and Input Capture

This block is a 16-bit up-counter with two wide operating modes, selected by a mode input. In auto-reload mode, the counter runs until it rolls past its top value. It then restarts from a value held in a 16-bit reload register. In capture mode, the counter runs freely and wraps to zero. A chosen edge on an external input copies the running count into that same register. The reload register therefore serves as the restart value in one mode and as the capture latch in the other.

The count advances only while the run input is high, and only in a cycle when the chosen count source offers a step. There are four sources: every clock, every twelfth clock from an internal divider, a slow tick strobe, and a slower pulse strobe. Capture works whether or not the counter is running. The block has two sticky flags, one for the high half and one for the low byte. Each flag drives an interrupt line through a global interrupt enable. Software clears a flag with a clear strobe, which stands in for writing zero to it. Software can also load the count and the reload register directly.

Top module: `reload_capture_timer`

## Requirements
- R1: After reset the count, the reload register, both flags and both interrupt outputs are zero.
- R2: The count changes only on a clock edge where run_en is high and the chosen source offers a step; with run_en low it holds its value.
- R3: src_sel picks the step source: 0 = every clock, 1 = one clock in every 12 from a free-running divider that starts at reset, 2 = tick_stb, 3 = pulse_stb. A strobe that is not selected has no effect.
- R4: With mode_cap = 0, a step from 0xFFFF loads the reload value into the count and sets flag_hi.
- R5: With mode_cap = 0 and low_ie = 1, a step from a count whose low 8 bits are 0xFF sets flag_lo. With low_ie = 0 it does not.
- R6: With mode_cap = 1, a step from 0xFFFF gives a count of 0x0000 and sets flag_lo. It leaves the reload register and flag_hi unchanged.
- R7: With mode_cap = 1, a selected edge on cap_in copies the count into the reload register and sets flag_hi. The edge is detected after a two-flop synchronizer. cap_edge encodes the selection as 0 = none, 1 = rising, 2 = falling, 3 = both.
- R8: A capture still latches the count and sets flag_hi while run_en is low.
- R9: A capture in the same cycle as a 16-bit wrap latches the count from before the step.
- R10: clr_hi and clr_lo clear their flag on the next edge. A hardware set in the same cycle wins over the clear.
- R11: irq_hi = flag_hi AND glb_ie, and irq_lo = flag_lo AND glb_ie.
- R12: wr_cnt loads cnt_wdata into the count, taking priority over a step. wr_rld loads rld_wdata into the reload register unless a capture happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter run enable |
| mode_cap | input | 1 | 0 = auto-reload, 1 = capture |
| src_sel | input | 2 | Step source select |
| tick_stb | input | 1 | Slow tick strobe, one cycle wide |
| pulse_stb | input | 1 | Slower pulse strobe, one cycle wide |
| cap_in | input | 1 | Asynchronous external capture input |
| cap_edge | input | 2 | Capture edge select |
| low_ie | input | 1 | Low-byte flag enable in auto-reload mode |
| glb_ie | input | 1 | Global interrupt enable |
| wr_cnt | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write data |
| wr_rld | input | 1 | Reload register write strobe |
| rld_wdata | input | 16 | Reload register write data |
| clr_hi | input | 1 | High-half flag clear strobe |
| clr_lo | input | 1 | Low-byte flag clear strobe |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Reload / capture register |
| flag_hi | output | 1 | High-half flag |
| flag_lo | output | 1 | Low-byte flag |
| irq_hi | output | 1 | High-half interrupt |
| irq_lo | output | 1 | Low-byte interrupt |

## Verification
The following effects show up right after the clock edge that consumes them, one edge after the stimulus: steps, wraps, flag sets and clears, and register writes. The bench drives every input on a falling edge and samples on the next falling edge.

A cap_in change is captured on the third rising edge after the change. The bench waits two edges, reads count_o as the expected captured value, and then checks reload_o one edge later. The interrupt outputs follow the flags with no added latency, so they are compared in the same sample as the flags.

For the divided source, the divider phase is not visible. The bench therefore runs a whole number of 12-clock windows and expects an exact step count.

// File: rtl/rct_pkg.sv
package rct_pkg;
   typedef enum logic [1:0] {
      SRC_CLK   = 2'd0,
      SRC_DIV   = 2'd1,
      SRC_TICK  = 2'd2,
      SRC_PULSE = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_e;

   localparam int FLAG_HI = 0;
   localparam int FLAG_LO = 1;
endpackage

// File: rtl/rct_srcsel.sv
module rct_srcsel #(
   parameter int DIV_N = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_en,
   input  logic [1:0] src_sel,
   input  logic       tick_stb,
   input  logic       pulse_stb,
   output logic       adv
);
   import rct_pkg::*;

   localparam int DW = (DIV_N > 1) ? $clog2(DIV_N) : 1;
   localparam logic [DW-1:0] DIV_LAST = DW'(DIV_N - 1);

   if (DIV_N < 2) begin : g_bad_div
      $error("rct_srcsel: DIV_N must be at least 2");
   end

   logic [DW-1:0] div_q;
   logic          div_stb;
   logic          src_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (div_q == DIV_LAST)
         div_q <= '0;
      else
         div_q <= div_q + DW'(1);
   end

   assign div_stb = (div_q == DIV_LAST);

   always_comb begin
      case (src_sel)
         SRC_CLK:   src_ok = 1'b1;
         SRC_DIV:   src_ok = div_stb;
         SRC_TICK:  src_ok = tick_stb;
         default:   src_ok = pulse_stb;
      endcase
   end

   assign adv = run_en & src_ok;

   // R3
   div_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_stb |=> !div_stb);
endmodule

// File: rtl/rct_edge.sv
module rct_edge #(
   parameter int SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cap_in,
   input  logic [1:0] cap_edge,
   output logic       cap_evt
);
   import rct_pkg::*;

   if (SYNC_N < 2) begin : g_bad_sync
      $error("rct_edge: SYNC_N must be at least 2");
   end

   logic [SYNC_N-1:0] sync_q;
   logic              prev_q;
   logic              lvl;
   logic              rise;
   logic              fall;

   for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= cap_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign lvl = sync_q[SYNC_N-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   always_comb begin
      case (cap_edge)
         EDGE_RISE: cap_evt = rise;
         EDGE_FALL: cap_evt = fall;
         EDGE_BOTH: cap_evt = rise | fall;
         default:   cap_evt = 1'b0;
      endcase
   end

   // R7
   evt_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |-> (lvl != prev_q));
endmodule

// File: rtl/rct_core.sv
module rct_core #(
   parameter int CNT_W = 16,
   parameter int LOW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_cap,
   input  logic             adv,
   input  logic             cap_evt,
   input  logic             wr_cnt,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             wr_rld,
   input  logic [CNT_W-1:0] rld_wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] rld,
   output logic             wrap_evt,
   output logic             low_evt,
   output logic             cap_take
);
   logic             step;
   logic [CNT_W-1:0] cnt_nxt;

   assign step     = adv & ~wr_cnt;
   assign wrap_evt = step & (&cnt);
   assign low_evt  = step & (&cnt[LOW_W-1:0]);
   assign cap_take = mode_cap & cap_evt;

   always_comb begin
      if (wr_cnt)
         cnt_nxt = cnt_wdata;
      else if (wrap_evt)
         cnt_nxt = mode_cap ? '0 : rld;
      else if (step)
         cnt_nxt = cnt + CNT_W'(1);
      else
         cnt_nxt = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rld <= '0;
      else if (cap_take)
         rld <= cnt;
      else if (wr_rld)
         rld <= rld_wdata;
   end

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !wr_cnt) |=> $stable(cnt));

   // R4
   reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_cap && adv && !wr_cnt && (&cnt)) |=> (cnt == $past(rld)));

   // R9
   capture_pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cap && cap_evt) |=> (rld == $past(cnt)));
endmodule

// File: rtl/rct_flags.sv
module rct_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_cap,
   input  logic wrap_evt,
   input  logic low_evt,
   input  logic cap_take,
   input  logic low_ie,
   input  logic clr_hi,
   input  logic clr_lo,
   input  logic glb_ie,
   output logic flag_hi,
   output logic flag_lo,
   output logic irq_hi,
   output logic irq_lo
);
   import rct_pkg::*;

   logic [1:0] set_v;
   logic [1:0] clr_v;
   logic [1:0] flag_q;

   assign set_v[FLAG_HI] = mode_cap ? cap_take : wrap_evt;
   assign set_v[FLAG_LO] = mode_cap ? wrap_evt : (low_evt & low_ie);
   assign clr_v[FLAG_HI] = clr_hi;
   assign clr_v[FLAG_LO] = clr_lo;

   for (genvar f = 0; f < 2; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q[f] <= 1'b0;
         else if (set_v[f])
            flag_q[f] <= 1'b1;
         else if (clr_v[f])
            flag_q[f] <= 1'b0;
      end

      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_v[f] |=> flag_q[f]);
   end

   assign flag_hi = flag_q[FLAG_HI];
   assign flag_lo = flag_q[FLAG_LO];
   assign irq_hi  = flag_hi & glb_ie;
   assign irq_lo  = flag_lo & glb_ie;
endmodule

// File: rtl/reload_capture_timer.sv
module reload_capture_timer #(
   parameter int CNT_W  = 16,
   parameter int LOW_W  = 8,
   parameter int DIV_N  = 12,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             mode_cap,
   input  logic [1:0]       src_sel,
   input  logic             tick_stb,
   input  logic             pulse_stb,
   input  logic             cap_in,
   input  logic [1:0]       cap_edge,
   input  logic             low_ie,
   input  logic             glb_ie,
   input  logic             wr_cnt,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             wr_rld,
   input  logic [CNT_W-1:0] rld_wdata,
   input  logic             clr_hi,
   input  logic             clr_lo,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             flag_hi,
   output logic             flag_lo,
   output logic             irq_hi,
   output logic             irq_lo
);
   if (LOW_W < 1 || LOW_W >= CNT_W) begin : g_bad_width
      $error("reload_capture_timer: LOW_W must lie in 1..CNT_W-1");
   end

   logic adv;
   logic cap_evt;
   logic wrap_evt;
   logic low_evt;
   logic cap_take;

   rct_srcsel #(.DIV_N(DIV_N)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .src_sel   (src_sel),
      .tick_stb  (tick_stb),
      .pulse_stb (pulse_stb),
      .adv       (adv)
   );

   rct_edge #(.SYNC_N(SYNC_N)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_in   (cap_in),
      .cap_edge (cap_edge),
      .cap_evt  (cap_evt)
   );

   rct_core #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_cap  (mode_cap),
      .adv       (adv),
      .cap_evt   (cap_evt),
      .wr_cnt    (wr_cnt),
      .cnt_wdata (cnt_wdata),
      .wr_rld    (wr_rld),
      .rld_wdata (rld_wdata),
      .cnt       (count_o),
      .rld       (reload_o),
      .wrap_evt  (wrap_evt),
      .low_evt   (low_evt),
      .cap_take  (cap_take)
   );

   rct_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_cap (mode_cap),
      .wrap_evt (wrap_evt),
      .low_evt  (low_evt),
      .cap_take (cap_take),
      .low_ie   (low_ie),
      .clr_hi   (clr_hi),
      .clr_lo   (clr_lo),
      .glb_ie   (glb_ie),
      .flag_hi  (flag_hi),
      .flag_lo  (flag_lo),
      .irq_hi   (irq_hi),
      .irq_lo   (irq_lo)
   );

   // R6
   capture_wrap_keeps_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cap && wrap_evt && !cap_evt && !wr_rld) |=> ((count_o == '0) && $stable(reload_o)));
endmodule

// File: tb/reload_capture_timer_tb.sv
module reload_capture_timer_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0, mode_cap = 1'b0;
   logic [1:0]  src_sel = 2'd0;
   logic        tick_stb = 1'b0, pulse_stb = 1'b0;
   logic        cap_in = 1'b0;
   logic [1:0]  cap_edge = 2'd0;
   logic        low_ie = 1'b0, glb_ie = 1'b0;
   logic        wr_cnt = 1'b0, wr_rld = 1'b0;
   logic [15:0] cnt_wdata = '0, rld_wdata = '0;
   logic        clr_hi = 1'b0, clr_lo = 1'b0;
   logic [15:0] count_o, reload_o;
   logic        flag_hi, flag_lo, irq_hi, irq_lo;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   reload_capture_timer u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_cap(mode_cap),
      .src_sel(src_sel), .tick_stb(tick_stb), .pulse_stb(pulse_stb),
      .cap_in(cap_in), .cap_edge(cap_edge), .low_ie(low_ie), .glb_ie(glb_ie),
      .wr_cnt(wr_cnt), .cnt_wdata(cnt_wdata), .wr_rld(wr_rld), .rld_wdata(rld_wdata),
      .clr_hi(clr_hi), .clr_lo(clr_lo), .count_o(count_o), .reload_o(reload_o),
      .flag_hi(flag_hi), .flag_lo(flag_lo), .irq_hi(irq_hi), .irq_lo(irq_lo)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put_cnt(input logic [15:0] v);
      wr_cnt = 1'b1; cnt_wdata = v;
      step(1);
      wr_cnt = 1'b0;
   endtask

   task automatic put_rld(input logic [15:0] v);
      wr_rld = 1'b1; rld_wdata = v;
      step(1);
      wr_rld = 1'b0;
   endtask

   task automatic clear_flags();
      clr_hi = 1'b1; clr_lo = 1'b1;
      step(1);
      clr_hi = 1'b0; clr_lo = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] exp_v, prev_r, c0;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      chk(count_o == 16'h0 && reload_o == 16'h0, "R1 regs", {count_o, reload_o}, 0);
      chk({flag_hi, flag_lo, irq_hi, irq_lo} == 4'b0, "R1 flags", {flag_hi, flag_lo, irq_hi, irq_lo}, 0);

      // R12 software writes
      put_rld(16'h1234);
      chk(reload_o == 16'h1234, "R12 reload write", reload_o, 16'h1234);
      put_cnt(16'h00AA);
      chk(count_o == 16'h00AA, "R12 count write", count_o, 16'h00AA);
      run_en = 1'b1;
      put_cnt(16'h00C0);
      chk(count_o == 16'h00C0, "R12 write beats step", count_o, 16'h00C0);
      run_en = 1'b0;

      // R2 stopped holds
      step(5);
      chk(count_o == 16'h00C0, "R2 hold when stopped", count_o, 16'h00C0);

      // R3 source 0: every clock
      run_en = 1'b1; step(7); run_en = 1'b0;
      chk(count_o == 16'h00C7, "R3 src clock", count_o, 16'h00C7);

      // R3 source 1: divide by 12, whole windows
      put_cnt(16'h0);
      src_sel = 2'd1;
      run_en = 1'b1; step(120); run_en = 1'b0;
      chk(count_o == 16'd10, "R3 src div12 120", count_o, 10);
      run_en = 1'b1; step(12); run_en = 1'b0;
      chk(count_o == 16'd11, "R3 src div12 12", count_o, 11);

      // R3 sources 2 and 3 with the other strobe as noise
      for (int s = 2; s <= 3; s++) begin
         int n_tick, n_pulse;
         src_sel = 2'(s);
         c0 = count_o;
         n_tick = 0; n_pulse = 0;
         run_en = 1'b1;
         for (int k = 0; k < 8; k++) begin
            tick_stb  = (k % 3 == 0);
            pulse_stb = (k % 3 != 0);
            if (tick_stb) n_tick++; else n_pulse++;
            step(1);
         end
         tick_stb = 1'b0; pulse_stb = 1'b0; run_en = 1'b0;
         exp_v = c0 + 16'((s == 2) ? n_tick : n_pulse);
         chk(count_o == exp_v, "R3 strobe source", count_o, exp_v);
      end

      // R4 / R11 sweep of reload values
      src_sel = 2'd0; mode_cap = 1'b0; low_ie = 1'b0;
      for (int i = 0; i < 16; i++) begin
         logic [15:0] r;
         r = 16'(i * 16'h1111) ^ 16'h00F0;
         glb_ie = i[0];
         put_rld(r);
         put_cnt(16'hFFFE);
         clear_flags();
         run_en = 1'b1; step(1);
         chk(count_o == 16'hFFFF && !flag_hi, "R4 before wrap", {count_o, 15'b0, flag_hi}, 32'hFFFF0000);
         step(1); run_en = 1'b0;
         chk(count_o == r, "R4 reload on wrap", count_o, r);
         chk(flag_hi == 1'b1, "R4 flag_hi", flag_hi, 1);
         chk(flag_lo == 1'b0, "R5 low flag off when disabled", flag_lo, 0);
         chk(irq_hi == i[0], "R11 irq_hi", irq_hi, i[0]);
      end

      // R5 low byte rollover
      clear_flags(); low_ie = 1'b1; glb_ie = 1'b1;
      put_cnt(16'h12FE);
      run_en = 1'b1; step(1);
      chk(flag_lo == 1'b0, "R5 no early flag", flag_lo, 0);
      step(1); run_en = 1'b0;
      chk(count_o == 16'h1300 && flag_lo && !flag_hi, "R5 low rollover", {count_o, 14'b0, flag_hi, flag_lo}, 32'h13000001);
      chk(irq_lo == 1'b1, "R11 irq_lo", irq_lo, 1);

      // R6 capture mode wrap
      mode_cap = 1'b1; low_ie = 1'b0; cap_edge = 2'd0;
      clear_flags();
      put_rld(16'h5555);
      put_cnt(16'hFFFE);
      run_en = 1'b1; step(2); run_en = 1'b0;
      chk(count_o == 16'h0 && reload_o == 16'h5555, "R6 free wrap", {count_o, reload_o}, 32'h00005555);
      chk(flag_lo && !flag_hi, "R6 flags", {flag_hi, flag_lo}, 1);

      // R7 edge select sweep while counting
      run_en = 1'b1;
      for (int sel = 0; sel < 4; sel++) begin
         cap_edge = 2'(sel);
         for (int d = 0; d < 2; d++) begin
            bit hit;
            clear_flags();
            prev_r = reload_o;
            cap_in = ~cap_in;
            hit = cap_in ? sel[0] : sel[1];
            step(2);
            exp_v = count_o;
            step(1);
            if (!hit) exp_v = prev_r;
            chk(reload_o == exp_v, "R7 capture value", reload_o, exp_v);
            chk(flag_hi == hit, "R7 capture flag", flag_hi, hit);
         end
      end
      run_en = 1'b0;

      // R8 capture while stopped
      cap_edge = 2'd3;
      clear_flags();
      put_cnt(16'h4321);
      cap_in = ~cap_in;
      step(3);
      chk(reload_o == 16'h4321 && count_o == 16'h4321, "R8 stopped capture", reload_o, 16'h4321);
      chk(flag_hi == 1'b1, "R8 stopped flag", flag_hi, 1);

      // R9 capture coincident with wrap
      src_sel = 2'd2; run_en = 1'b1;
      put_cnt(16'hFFFF);
      clear_flags();
      cap_in = ~cap_in;
      step(2);
      tick_stb = 1'b1;
      step(1);
      tick_stb = 1'b0;
      chk(reload_o == 16'hFFFF, "R9 pre-step count latched", reload_o, 16'hFFFF);
      chk(count_o == 16'h0 && flag_hi && flag_lo, "R9 wrap and flags", {count_o, 14'b0, flag_hi, flag_lo}, 3);

      // R10 clear and set-wins
      clr_hi = 1'b1; step(1); clr_hi = 1'b0;
      chk(!flag_hi && flag_lo, "R10 clear only hi", {flag_hi, flag_lo}, 1);
      clr_lo = 1'b1; step(1); clr_lo = 1'b0;
      chk(!flag_lo, "R10 clear lo", flag_lo, 0);
      cap_in = ~cap_in;
      step(2);
      clr_hi = 1'b1;
      step(1);
      clr_hi = 1'b0;
      chk(flag_hi == 1'b1, "R10 set beats clear", flag_hi, 1);
      glb_ie = 1'b0;
      step(1);
      chk(!irq_hi && flag_hi, "R11 masked irq", irq_hi, 0);
      run_en = 1'b0;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule